// File: doc/BRIEF.md
# Configurable GPIO port controller

This block controls an 8-bit bidirectional general-purpose port. Software sets four per-bit configuration registers through a simple synchronous register bus. These registers are pin direction, output data, open-drain select and pull-up request. From them the block derives three control signals per pin for an external pad: a driver enable, a driven level and a pull-up enable. A fifth, read-only address returns the live pin levels after a two-flop synchronizer. No filtering is applied, so a pin that is driven can be read back.

Open-drain behaviour is emulated per bit. The high-side drive is suppressed, so a 0 pulls the pin low and a 1 releases the driver. Each pull-up is switched off automatically whenever it would fight the driver. This happens for a push-pull output and for an open-drain output that is pulling low, whatever the pull-up register holds.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While reset is held and after it is released, the direction, output data and open-drain registers read 0x00 and the pull-up register reads 0xFF. With these values every pad_oe bit is 0 and every pad_pu_en bit is 1.
- R2: The register addresses are 0 for direction, 1 for output data, 2 for open-drain and 3 for pull-up. A write at one of these addresses takes effect at the next rising clock edge, and reading the same address returns the stored value in the same cycle. Address 4 is read-only, and a write to it changes no register. Addresses 5 to 7 read as 0x00.
- R3: A pin whose direction bit is 0 has pad_oe = 0, whatever its output data and open-drain bits hold.
- R4: A pin with direction 1 and open-drain 0 (push-pull) has pad_oe = 1 and pad_out equal to its output data bit.
- R5: A pin with direction 1 and open-drain 1 has pad_oe = 1 with pad_out = 0 when its output data bit is 0. When its output data bit is 1 it has pad_oe = 0.
- R6: pad_pu_en is 1 only when the pull-up register bit is 1 and the pin is either input-only or an open-drain output with data 1. It is 0 for push-pull outputs and for open-drain outputs driving low.
- R7: Reading address 4 returns the pin levels as sampled two rising edges earlier, with no filtering. A pulse one clock long is seen for exactly one cycle, and a driven output reads back its level.
- R8: pad_oe and pad_pu_en are never both 1 on the same pin.
- R9: pad_out is 0 on every pin whose pad_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 dir, 1 data, 2 open-drain, 3 pull-up, 4 pin levels) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the current address |
| pin_in | input | 8 | Pin levels from the pads |
| pad_oe | output | 8 | Per-pin driver enable |
| pad_out | output | 8 | Per-pin driven level |
| pad_pu_en | output | 8 | Per-pin pull-up enable |

## Verification
On an open-drain pin, a single write to the output data register makes the driver enable and the pull-up enable change at the same clock edge, and they change in opposite directions. The bench provokes this by flipping the data of open-drain bits between 0 and 1. It then samples half a cycle after the write edge to check that the driver released and the pull-up engaged together, with no cycle in which both or neither hold in an unexpected way. A loopback pad model in the bench makes the pulled-up or driven levels visible again through the input register two cycles later.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 3'd0,
    REG_DOUT = 3'd1,
    REG_ODEN = 3'd2,
    REG_PUEN = 3'd3,
    REG_PINS = 3'd4
  } gpio_reg_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_out_n
);

  logic [1:0] chain_q;
  logic [1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= 2'b00;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_out_n = chain_q[1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_async,
  output logic [NPINS-1:0] pin_sync
);

  logic [NPINS-1:0] stage_q [STAGES];
  logic [NPINS-1:0] stage_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stage_d[g] = pin_async;
    end else begin : g_next
      assign stage_d[g] = stage_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= '0;
      end else begin
        stage_q[g] <= stage_d[g];
      end
    end
  end

  assign pin_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int               NPINS  = 8,
  parameter logic [NPINS-1:0] PU_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wr_data,
  input  logic [NPINS-1:0]  pin_sync,
  output logic [NPINS-1:0]  rd_data,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  dout_q,
  output logic [NPINS-1:0]  od_q,
  output logic [NPINS-1:0]  pu_q
);

  logic wen_dir, wen_dout, wen_od, wen_pu;
  logic [NPINS-1:0] dir_d, dout_d, od_d, pu_d;

  // decode write strobes
  always_comb begin
    wen_dir  = wr_en && (addr == REG_DIR);
    wen_dout = wr_en && (addr == REG_DOUT);
    wen_od   = wr_en && (addr == REG_ODEN);
    wen_pu   = wr_en && (addr == REG_PUEN);
  end

  // next state
  always_comb begin
    dir_d  = wen_dir  ? wr_data : dir_q;
    dout_d = wen_dout ? wr_data : dout_q;
    od_d   = wen_od   ? wr_data : od_q;
    pu_d   = wen_pu   ? wr_data : pu_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      od_q   <= '0;
      pu_q   <= PU_RST;
    end else begin
      if (wen_dir)  dir_q  <= dir_d;
      if (wen_dout) dout_q <= dout_d;
      if (wen_od)   od_q   <= od_d;
      if (wen_pu)   pu_q   <= pu_d;
    end
  end

  // read mux, same-cycle
  always_comb begin
    case (addr)
      REG_DIR:  rd_data = dir_q;
      REG_DOUT: rd_data = dout_q;
      REG_ODEN: rd_data = od_q;
      REG_PUEN: rd_data = pu_q;
      REG_PINS: rd_data = pin_sync;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int NPINS = 8
) (
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] dout_q,
  input  logic [NPINS-1:0] od_q,
  input  logic [NPINS-1:0] pu_q,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_pu_en
);

  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    logic drive;
    logic released;

    always_comb begin
      // push-pull drives always; open-drain drives only a low
      drive        = dir_q[i] & (~od_q[i] | ~dout_q[i]);
      released     = ~dir_q[i] | (od_q[i] & dout_q[i]);
      pad_oe[i]    = drive;
      pad_out[i]   = drive & ~od_q[i] & dout_q[i];
      pad_pu_en[i] = pu_q[i] & released;
    end
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int               NPINS       = 8,
  parameter int               SYNC_STAGES = 2,
  parameter logic [NPINS-1:0] PU_RST      = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wr_data,
  output logic [NPINS-1:0]  rd_data,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_pu_en
);

  logic             rst_int_n;
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] dir_q, dout_q, od_q, pu_q;

  gpio_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_out_n (rst_int_n)
  );

  gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pin_async (pin_in),
    .pin_sync  (pin_sync)
  );

  gpio_cfg_regs #(.NPINS(NPINS), .PU_RST(PU_RST)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .pin_sync (pin_sync),
    .rd_data  (rd_data),
    .dir_q    (dir_q),
    .dout_q   (dout_q),
    .od_q     (od_q),
    .pu_q     (pu_q)
  );

  gpio_pad_ctrl #(.NPINS(NPINS)) u_pad (
    .dir_q     (dir_q),
    .dout_q    (dout_q),
    .od_q      (od_q),
    .pu_q      (pu_q),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu_en (pad_pu_en)
  );

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NPINS-1:0]  wr_data,
  input logic [NPINS-1:0]  rd_data,
  input logic [NPINS-1:0]  pin_in,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_pu_en,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  od_q,
  input logic [NPINS-1:0]  dout_q,
  input logic [NPINS-1:0]  pu_q
);

  logic [1:0] settle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= 2'd0;
    end else if (settle_q != 2'd3) begin
      settle_q <= settle_q + 2'd1;
    end
  end

  a_r2_dir_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_DIR) |=> (dir_q == $past(wr_data)));

  a_r2_pins_addr_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_PINS) |=> ($stable(dir_q) && $stable(dout_q) && $stable(od_q) && $stable(pu_q)));

  a_r3_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ((~dir_q & pad_oe) == '0));

  a_r4_pushpull_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (((dir_q & ~od_q) & ~pad_oe) == '0));

  a_r5_od_release: assert property (@(posedge clk) disable iff (!rst_n)
    (((dir_q & od_q & dout_q) & pad_oe) == '0));

  a_r6_pu_subset: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu_en & ~pu_q) == '0));

  a_r7_sync_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q == 2'd3 && addr == REG_PINS) |-> (rd_data == $past(pin_in, 2)));

  a_r8_no_pull_while_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & pad_pu_en) == '0));

  a_r9_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~pad_oe) == '0));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPINS(NPINS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .wr_en     (wr_en),
  .addr      (addr),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .pin_in    (pin_in),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .pad_pu_en (pad_pu_en),
  .dir_q     (dir_q),
  .od_q      (od_q),
  .dout_q    (dout_q),
  .pu_q      (pu_q)
);

// File: tb/gpio_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb_top;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [7:0] pin_in;
  logic [7:0] pad_oe;
  logic [7:0] pad_out;
  logic [7:0] pad_pu_en;
  logic [7:0] ext_val;

  int n_cmp = 0;
  int n_bad = 0;

  gpio_port_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .pin_in    (pin_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu_en (pad_pu_en)
  );

  // pad model: driver wins, then pull-up, then external level
  always_comb begin
    for (int i = 0; i < 8; i++) begin
      pin_in[i] = pad_oe[i] ? pad_out[i] : (pad_pu_en[i] ? 1'b1 : ext_val[i]);
    end
  end

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic cfg(input logic [7:0] dir, input logic [7:0] dout,
                     input logic [7:0] od, input logic [7:0] pu);
    wr(3'd0, dir); wr(3'd1, dout); wr(3'd2, od); wr(3'd3, pu);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #0.5;
    chk("R1 oe in reset", pad_oe, 8'h00);
    chk("R1 pu in reset", pad_pu_en, 8'hFF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd0, v); chk("R1 dir reset", v, 8'h00);
    rd(3'd1, v); chk("R1 dout reset", v, 8'h00);
    rd(3'd2, v); chk("R1 od reset", v, 8'h00);
    rd(3'd3, v); chk("R1 pu reset", v, 8'hFF);
    chk("R1 oe after reset", pad_oe, 8'h00);
    chk("R1 pu_en after reset", pad_pu_en, 8'hFF);
    chk("R9 out after reset", pad_out, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    cfg(8'h5A, 8'hC3, 8'h96, 8'h3C);
    rd(3'd0, v); chk("R2 dir readback", v, 8'h5A);
    rd(3'd1, v); chk("R2 dout readback", v, 8'hC3);
    rd(3'd2, v); chk("R2 od readback", v, 8'h96);
    rd(3'd3, v); chk("R2 pu readback", v, 8'h3C);
    wr(3'd4, 8'h00);
    rd(3'd0, v); chk("R2 dir after pins write", v, 8'h5A);
    rd(3'd1, v); chk("R2 dout after pins write", v, 8'hC3);
    rd(3'd2, v); chk("R2 od after pins write", v, 8'h96);
    rd(3'd3, v); chk("R2 pu after pins write", v, 8'h3C);
    rd(3'd5, v); chk("R2 addr5 reads zero", v, 8'h00);
    rd(3'd7, v); chk("R2 addr7 reads zero", v, 8'h00);
  endtask

  task automatic t_input_only();
    cfg(8'h00, 8'hFF, 8'h0F, 8'hA5);
    #0.5;
    chk("R3 oe input-only", pad_oe, 8'h00);
    chk("R9 out input-only", pad_out, 8'h00);
    chk("R6 pu_en input-only", pad_pu_en, 8'hA5);
  endtask

  task automatic t_pushpull();
    logic [7:0] v;
    ext_val = 8'h00;
    cfg(8'hFF, 8'hA5, 8'h00, 8'hFF);
    #0.5;
    chk("R4 oe push-pull", pad_oe, 8'hFF);
    chk("R4 out push-pull", pad_out, 8'hA5);
    chk("R6 pu_en push-pull", pad_pu_en, 8'h00);
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R7 readback driven", v, 8'hA5);
  endtask

  task automatic t_opendrain();
    logic [7:0] v;
    ext_val = 8'h00;
    cfg(8'hFF, 8'h0F, 8'hFF, 8'hFF);
    #0.5;
    chk("R5 oe open-drain", pad_oe, 8'hF0);
    chk("R5 out open-drain", pad_out, 8'h00);
    chk("R6 pu_en open-drain", pad_pu_en, 8'h0F);
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R7 open-drain pins", v, 8'h0F);
    // flip data: release and pull-up move at the same edge
    wr(3'd1, 8'hF0);
    #0.5;
    chk("R5 oe after flip", pad_oe, 8'h0F);
    chk("R6 pu_en after flip", pad_pu_en, 8'hF0);
    chk("R8 no overlap after flip", pad_oe & pad_pu_en, 8'h00);
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R7 pins after flip", v, 8'hF0);
  endtask

  task automatic t_mixed();
    cfg(8'h3C, 8'h14, 8'h30, 8'h99);
    #0.5;
    chk("R4 R5 oe mixed", pad_oe, 8'h2C);
    chk("R4 R9 out mixed", pad_out, 8'h04);
    chk("R6 pu_en mixed", pad_pu_en, 8'h91);
    chk("R8 no overlap mixed", pad_oe & pad_pu_en, 8'h00);
  endtask

  task automatic t_pulse();
    logic [7:0] v;
    ext_val = 8'h00;
    cfg(8'h00, 8'h00, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R7 idle low", v, 8'h00);
    @(negedge clk);
    ext_val = 8'h01;
    @(negedge clk); #0.5;
    chk("R7 one edge lag", rd_data, 8'h00);
    ext_val = 8'h00;
    @(negedge clk); #0.5;
    chk("R7 pulse seen", rd_data, 8'h01);
    @(negedge clk); #0.5;
    chk("R7 pulse gone", rd_data, 8'h00);
  endtask

  task automatic t_mid_reset();
    logic [7:0] v;
    cfg(8'hFF, 8'hFF, 8'h00, 8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk("R1 oe async reset", pad_oe, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd0, v); chk("R1 dir after mid reset", v, 8'h00);
    rd(3'd3, v); chk("R1 pu after mid reset", v, 8'hFF);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 3'd0; wr_data = 8'h00; ext_val = 8'h00;
    t_reset();
    t_regs();
    t_input_only();
    t_pushpull();
    t_opendrain();
    t_mixed();
    t_pulse();
    t_mid_reset();
    summary();
    $finish;
  end

endmodule